// File: doc/BRIEF.md
# Latency Feedback QoS Controller

This block produces the 4-bit QoS value that travels with each write and read address request. Each channel runs its own feedback loop. It measures a delay, takes the difference from a programmed target, and adds that difference to a 16-bit integrator that cannot go below zero or above its maximum. The integrator is divided by a programmable power of two and clamped to a programmed window, and the result is the priority. A master whose requests wait longer than intended therefore sees its priority rise. A master that is served faster than its target sees its priority fall back.

Each channel can measure one of two delays. The first is the transaction latency: the number of cycles from an accepted address to its accepted completion. Completions are matched in order against the outstanding addresses. The second is the address request period: the number of cycles between two successive accepted addresses on that channel. When a channel is disabled, the incoming QoS value goes straight to the output. Turning the enable off and back on clears all loop state, which acts as a soft reset.

Top module: `qos_latency_ctrl`

## Requirements
- R1: While a channel's enable is low, its output QoS equals its incoming QoS in the same cycle. Channel index 0 is write and index 1 is read.
- R2: While a channel is enabled with a target of zero, the output QoS equals the incoming QoS and measurements leave the integrator unchanged.
- R3: Holding the enable low for at least one clock edge clears the channel's integrator and measurement state. After the enable returns, the output equals the programmed minimum until a measurement lands.
- R4: With mode bit 0, the measurement is the number of cycles from an accepted address to the next in-order accepted completion. A completion that arrives with no address outstanding produces no measurement.
- R5: With mode bit 1, the measurement is the number of cycles between two successive accepted addresses. The first address after enable only sets the reference.
- R6: Each measurement adds (measured minus target) to a 16-bit integrator that saturates at 0 and at 65535. Successive measurements accumulate.
- R7: The output QoS is the integrator shifted right by (3 + scale code), with a scale code of 0 to 7, then clamped to the window [minimum, maximum]. It changes in the cycle after the handshake that completes a measurement.
- R8: Measured intervals saturate at 4095 cycles.
- R9: In mode 0, at most 8 addresses are tracked. An address accepted while 8 are outstanding and none completes in that cycle is not recorded.
- R10: A handshake counts only when both valid and ready are high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_valid | input | NCH | Address request valid, per channel |
| addr_ready | input | NCH | Address request ready, per channel |
| cpl_valid | input | NCH | Completion valid, per channel |
| cpl_ready | input | NCH | Completion ready, per channel |
| qos_in | input | NCH x QOS_W | Incoming QoS value, per channel |
| cfg_enable | input | NCH | Regulation enable; a low pulse acts as a soft reset |
| cfg_mode | input | NCH | 0: transaction latency, 1: address request period |
| cfg_target | input | NCH x CNT_W | Target in cycles; zero disables regulation |
| cfg_scale | input | NCH x SCL_W | Gain code, shift = 3 + code |
| cfg_qos_min | input | NCH x QOS_W | Lower clamp of the generated QoS |
| cfg_qos_max | input | NCH x QOS_W | Upper clamp of the generated QoS |
| qos_out | output | NCH x QOS_W | QoS value to attach to the request |

## Verification
The bench builds the block with its default parameters: two channels, an 8-deep tracking queue, 12-bit counters and a 16-bit integrator. With these values, nine back-to-back addresses are enough to overflow the queue. A single 5000-cycle transaction shows the 4095-cycle saturation. Seventeen saturated periods push the integrator past 65535, which shows the upper clamp within the run time. A table of single-transaction cases covers the scale codes, the clamp window on both sides and negative errors. Directed sequences then cover accumulation, pass-through, soft reset, period mode and incomplete handshakes.

// File: rtl/qlc_pkg.sv
package qlc_pkg;
    localparam int CH_WR = 0;
    localparam int CH_RD = 1;

    typedef enum logic {
        MEAS_TXN    = 1'b0,
        MEAS_PERIOD = 1'b1
    } meas_mode_e;
endpackage

// File: rtl/qlc_measure.sv
module qlc_measure #(
    parameter int CNT_W = 12,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             mode,
    input  logic             addr_fire,
    input  logic             cpl_fire,
    output logic             meas_vld,
    output logic [CNT_W-1:0] meas_val
);
    localparam int OCC_W = $clog2(DEPTH + 1);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [DEPTH-1:0][CNT_W-1:0] age;
        logic [OCC_W-1:0]            occ;
        logic [CNT_W-1:0]            gap;
        logic                        seen;
    } meas_st_t;

    meas_st_t st_d, st_q;

    function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
        return (v == CNT_MAX) ? v : v + 1'b1;
    endfunction

    logic             pop, push;
    logic [OCC_W-1:0] occ_mid;

    always_comb begin
        st_d     = st_q;
        meas_vld = 1'b0;
        meas_val = '0;

        // age every tracked request by one cycle
        for (int i = 0; i < DEPTH; i++) begin
            if (i < int'(st_q.occ)) st_d.age[i] = sat_inc(st_q.age[i]);
        end

        // oldest entry retires on completion
        pop = cpl_fire && (st_q.occ != '0);
        if (pop) begin
            for (int i = 0; i < DEPTH - 1; i++) st_d.age[i] = st_d.age[i+1];
            st_d.age[DEPTH-1] = '0;
        end
        occ_mid = st_q.occ - OCC_W'(pop);

        push = addr_fire && (occ_mid < OCC_W'(DEPTH));
        if (push) st_d.age[occ_mid[IDX_W-1:0]] = CNT_W'(1);
        st_d.occ = occ_mid + OCC_W'(push);

        // interval since previous accepted address
        if (addr_fire) begin
            st_d.gap  = CNT_W'(1);
            st_d.seen = 1'b1;
        end else begin
            st_d.gap  = sat_inc(st_q.gap);
        end

        if (mode == qlc_pkg::MEAS_PERIOD) begin
            meas_vld = addr_fire && st_q.seen;
            meas_val = st_q.gap;
        end else begin
            meas_vld = pop;
            meas_val = st_q.age[0];
        end

        if (!en) begin
            st_d     = '0;
            meas_vld = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/qlc_integrator.sv
module qlc_integrator #(
    parameter int CNT_W      = 12,
    parameter int ACC_W      = 16,
    parameter int QOS_W      = 4,
    parameter int SCL_W      = 3,
    parameter int SHIFT_BASE = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [CNT_W-1:0] target,
    input  logic [SCL_W-1:0] scale,
    input  logic [QOS_W-1:0] qos_min,
    input  logic [QOS_W-1:0] qos_max,
    input  logic [QOS_W-1:0] qos_in,
    input  logic             meas_vld,
    input  logic [CNT_W-1:0] meas_val,
    output logic [QOS_W-1:0] qos_out
);
    localparam int SUM_W = ((ACC_W > CNT_W) ? ACC_W : CNT_W) + 2;
    localparam int SH_W  = $clog2(SHIFT_BASE + (1 << SCL_W) + 1);

    typedef struct packed {
        logic [ACC_W-1:0] acc;
    } integ_st_t;

    integ_st_t st_d, st_q;

    logic                    active;
    logic signed [SUM_W-1:0] sum;
    logic [ACC_W-1:0]        acc_sat;
    logic [SH_W-1:0]         shamt;
    logic [ACC_W-1:0]        raw;
    logic [QOS_W-1:0]        lvl;

    always_comb begin
        st_d   = st_q;
        active = en && (target != '0);

        sum = $signed(SUM_W'(st_q.acc)) + $signed(SUM_W'(meas_val))
            - $signed(SUM_W'(target));
        if (sum < 0)                                acc_sat = '0;
        else if (sum > $signed(SUM_W'({ACC_W{1'b1}}))) acc_sat = '1;
        else                                        acc_sat = sum[ACC_W-1:0];

        if (!en)                      st_d.acc = '0;
        else if (active && meas_vld)  st_d.acc = acc_sat;

        shamt = SH_W'(SHIFT_BASE) + SH_W'(scale);
        raw   = st_q.acc >> shamt;
        lvl   = (raw > ACC_W'(qos_max)) ? qos_max : raw[QOS_W-1:0];
        if (lvl < qos_min) lvl = qos_min;

        qos_out = active ? lvl : qos_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/qos_latency_ctrl.sv
module qos_latency_ctrl #(
    parameter int NCH   = 2,
    parameter int CNT_W = 12,
    parameter int ACC_W = 16,
    parameter int QOS_W = 4,
    parameter int SCL_W = 3,
    parameter int DEPTH = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NCH-1:0]              addr_valid,
    input  logic [NCH-1:0]              addr_ready,
    input  logic [NCH-1:0]              cpl_valid,
    input  logic [NCH-1:0]              cpl_ready,
    input  logic [NCH-1:0][QOS_W-1:0]   qos_in,
    input  logic [NCH-1:0]              cfg_enable,
    input  logic [NCH-1:0]              cfg_mode,
    input  logic [NCH-1:0][CNT_W-1:0]   cfg_target,
    input  logic [NCH-1:0][SCL_W-1:0]   cfg_scale,
    input  logic [NCH-1:0][QOS_W-1:0]   cfg_qos_min,
    input  logic [NCH-1:0][QOS_W-1:0]   cfg_qos_max,
    output logic [NCH-1:0][QOS_W-1:0]   qos_out
);
    localparam int SHIFT_BASE = 3;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic             addr_fire, cpl_fire;
        logic             meas_vld;
        logic [CNT_W-1:0] meas_val;

        assign addr_fire = addr_valid[c] & addr_ready[c];
        assign cpl_fire  = cpl_valid[c]  & cpl_ready[c];

        qlc_measure #(
            .CNT_W (CNT_W),
            .DEPTH (DEPTH)
        ) u_meas (
            .clk       (clk),
            .rst_n     (rst_n),
            .en        (cfg_enable[c]),
            .mode      (cfg_mode[c]),
            .addr_fire (addr_fire),
            .cpl_fire  (cpl_fire),
            .meas_vld  (meas_vld),
            .meas_val  (meas_val)
        );

        qlc_integrator #(
            .CNT_W      (CNT_W),
            .ACC_W      (ACC_W),
            .QOS_W      (QOS_W),
            .SCL_W      (SCL_W),
            .SHIFT_BASE (SHIFT_BASE)
        ) u_integ (
            .clk      (clk),
            .rst_n    (rst_n),
            .en       (cfg_enable[c]),
            .target   (cfg_target[c]),
            .scale    (cfg_scale[c]),
            .qos_min  (cfg_qos_min[c]),
            .qos_max  (cfg_qos_max[c]),
            .qos_in   (qos_in[c]),
            .meas_vld (meas_vld),
            .meas_val (meas_val),
            .qos_out  (qos_out[c])
        );
    end
endmodule

// File: rtl/qos_latency_ctrl_checker.sv
module qos_latency_ctrl_checker #(
    parameter int NCH   = 2,
    parameter int CNT_W = 12,
    parameter int QOS_W = 4
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [NCH-1:0]            cfg_enable,
    input logic [NCH-1:0][CNT_W-1:0] cfg_target,
    input logic [NCH-1:0][QOS_W-1:0] cfg_qos_min,
    input logic [NCH-1:0][QOS_W-1:0] cfg_qos_max,
    input logic [NCH-1:0][QOS_W-1:0] qos_in,
    input logic [NCH-1:0][QOS_W-1:0] qos_out
);
    for (genvar c = 0; c < NCH; c++) begin : g_chk
        // R1: disabled channel forwards the incoming value
        a_r1_disabled_passthru: assert property (@(posedge clk) disable iff (!rst_n)
            !cfg_enable[c] |-> qos_out[c] == qos_in[c]);

        // R2: zero target forwards the incoming value
        a_r2_zero_target_passthru: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_enable[c] && cfg_target[c] == '0) |-> qos_out[c] == qos_in[c]);

        // R3: a fresh enable starts from the programmed minimum
        a_r3_soft_reset_min: assert property (@(posedge clk) disable iff (!rst_n)
            ($rose(cfg_enable[c]) && cfg_target[c] != '0 && cfg_qos_min[c] <= cfg_qos_max[c])
            |-> qos_out[c] == cfg_qos_min[c]);

        // R7: regulated output stays inside the window
        a_r7_clamp_window: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_enable[c] && cfg_target[c] != '0 && cfg_qos_min[c] <= cfg_qos_max[c])
            |-> (qos_out[c] >= cfg_qos_min[c] && qos_out[c] <= cfg_qos_max[c]));
    end
endmodule

bind qos_latency_ctrl qos_latency_ctrl_checker #(
    .NCH   (NCH),
    .CNT_W (CNT_W),
    .QOS_W (QOS_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_enable  (cfg_enable),
    .cfg_target  (cfg_target),
    .cfg_qos_min (cfg_qos_min),
    .cfg_qos_max (cfg_qos_max),
    .qos_in      (qos_in),
    .qos_out     (qos_out)
);

// File: tb/qos_latency_ctrl_tb.sv
`timescale 1ns/1ps
module qos_latency_ctrl_tb;
    localparam int NCH = 2;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [NCH-1:0]       addr_valid = '0, addr_ready = '0;
    logic [NCH-1:0]       cpl_valid = '0, cpl_ready = '0;
    logic [NCH-1:0][3:0]  qos_in = '0;
    logic [NCH-1:0]       cfg_enable = '0, cfg_mode = '0;
    logic [NCH-1:0][11:0] cfg_target = '0;
    logic [NCH-1:0][2:0]  cfg_scale = '0;
    logic [NCH-1:0][3:0]  cfg_qos_min = '0, cfg_qos_max = '0;
    logic [NCH-1:0][3:0]  qos_out;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    qos_latency_ctrl u_dut (
        .clk(clk), .rst_n(rst_n),
        .addr_valid(addr_valid), .addr_ready(addr_ready),
        .cpl_valid(cpl_valid), .cpl_ready(cpl_ready),
        .qos_in(qos_in), .cfg_enable(cfg_enable), .cfg_mode(cfg_mode),
        .cfg_target(cfg_target), .cfg_scale(cfg_scale),
        .cfg_qos_min(cfg_qos_min), .cfg_qos_max(cfg_qos_max),
        .qos_out(qos_out)
    );

    typedef struct packed {
        logic        ch;
        logic [11:0] lat;
        logic [11:0] tgt;
        logic [2:0]  scl;
        logic [3:0]  mn;
        logic [3:0]  mx;
        logic [3:0]  exp;
    } vec_t;

    // single transaction from a cleared integrator: exp = clamp(max(0,lat-tgt) >> (3+scl))
    localparam vec_t VECS [0:5] = '{
        '{1'b0, 12'd40,  12'd8,  3'd0, 4'd0, 4'd15, 4'd4},
        '{1'b1, 12'd40,  12'd8,  3'd0, 4'd0, 4'd3,  4'd3},
        '{1'b0, 12'd10,  12'd20, 3'd0, 4'd2, 4'd15, 4'd2},
        '{1'b1, 12'd200, 12'd8,  3'd2, 4'd0, 4'd15, 4'd6},
        '{1'b0, 12'd100, 12'd4,  3'd1, 4'd7, 4'd15, 4'd7},
        '{1'b1, 12'd17,  12'd1,  3'd0, 4'd0, 4'd15, 4'd2}
    };

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic setup(input int c, input bit md, input int tgt, input int scl,
                         input int mn, input int mx);
        @(negedge clk);
        cfg_enable[c]  = 1'b0;
        cfg_mode[c]    = md;
        cfg_target[c]  = 12'(tgt);
        cfg_scale[c]   = 3'(scl);
        cfg_qos_min[c] = 4'(mn);
        cfg_qos_max[c] = 4'(mx);
        @(negedge clk);
        cfg_enable[c]  = 1'b1;
    endtask

    task automatic pulse_addr(input int c);
        addr_valid[c] = 1'b1; addr_ready[c] = 1'b1;
        @(negedge clk);
        addr_valid[c] = 1'b0; addr_ready[c] = 1'b0;
    endtask

    task automatic pulse_cpl(input int c);
        cpl_valid[c] = 1'b1; cpl_ready[c] = 1'b1;
        @(negedge clk);
        cpl_valid[c] = 1'b0; cpl_ready[c] = 1'b0;
    endtask

    task automatic txn(input int c, input int lat);
        pulse_addr(c);
        repeat (lat - 1) @(negedge clk);
        pulse_cpl(c);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog R1..all actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // reset state
        cfg_enable[0] = 1'b1; cfg_target[0] = 12'd8; cfg_qos_min[0] = 4'd2; cfg_qos_max[0] = 4'd15;
        qos_in[1] = 4'd6;
        #1;
        chk("reset R3 min on enabled ch", int'(qos_out[0]), 2);
        chk("reset R1 passthru on disabled ch", int'(qos_out[1]), 6);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // table of single transactions
        for (int i = 0; i < 6; i++) begin
            automatic int c = int'(VECS[i].ch);
            setup(c, 1'b0, int'(VECS[i].tgt), int'(VECS[i].scl), int'(VECS[i].mn), int'(VECS[i].mx));
            pulse_addr(c);
            repeat (int'(VECS[i].lat) - 1) @(negedge clk);
            cpl_valid[c] = 1'b1; cpl_ready[c] = 1'b1;
            #1;
            chk($sformatf("vec%0d R7 unchanged before completion edge", i), int'(qos_out[c]), int'(VECS[i].mn));
            @(negedge clk);
            cpl_valid[c] = 1'b0; cpl_ready[c] = 1'b0;
            chk($sformatf("vec%0d R4 R6 R7 latency result", i), int'(qos_out[c]), int'(VECS[i].exp));
        end

        // R6 accumulation, then R3 soft reset
        setup(0, 1'b0, 8, 0, 1, 15);
        txn(0, 40);
        chk("R6 first measurement", int'(qos_out[0]), 4);
        txn(0, 40);
        chk("R6 accumulated measurements", int'(qos_out[0]), 8);
        cfg_enable[0] = 1'b0;
        @(negedge clk);
        cfg_enable[0] = 1'b1;
        #1;
        chk("R3 soft reset returns to minimum", int'(qos_out[0]), 1);

        // R4 completion with nothing outstanding
        pulse_cpl(0);
        chk("R4 stray completion ignored", int'(qos_out[0]), 1);

        // R1 pass-through while disabled
        @(negedge clk);
        cfg_enable[0] = 1'b0; qos_in[0] = 4'd5;
        #1;
        chk("R1 disabled passthru", int'(qos_out[0]), 5);
        qos_in[0] = 4'd11;
        #1;
        chk("R1 disabled passthru same cycle", int'(qos_out[0]), 11);

        // R2 zero target
        setup(1, 1'b0, 0, 0, 0, 15);
        qos_in[1] = 4'd9;
        #1;
        chk("R2 zero target passthru", int'(qos_out[1]), 9);
        txn(1, 40);
        chk("R2 zero target passthru after txn", int'(qos_out[1]), 9);
        cfg_target[1] = 12'd8;
        #1;
        chk("R2 integrator untouched by zero target", int'(qos_out[1]), 0);

        // R5 period mode; R10 valid without ready
        setup(0, 1'b1, 8, 0, 0, 15);
        pulse_addr(0);
        chk("R5 first address sets reference only", int'(qos_out[0]), 0);
        repeat (4) @(negedge clk);
        addr_valid[0] = 1'b1;
        @(negedge clk);
        addr_valid[0] = 1'b0;
        repeat (34) @(negedge clk);
        pulse_addr(0);
        chk("R5 R10 period of 40 cycles", int'(qos_out[0]), 4);

        // R9 queue overflow
        setup(1, 1'b0, 1, 0, 0, 15);
        for (int k = 0; k < 9; k++) pulse_addr(1);
        @(negedge clk);
        for (int k = 0; k < 9; k++) pulse_cpl(1);
        chk("R9 ninth outstanding address dropped", int'(qos_out[1]), 9);

        // R8 measurement saturation
        setup(0, 1'b0, 1, 6, 0, 15);
        txn(0, 5000);
        chk("R8 latency saturates at 4095", int'(qos_out[0]), 7);

        // R6 integrator upper saturation
        setup(1, 1'b1, 1, 7, 0, 15);
        for (int k = 0; k < 18; k++) begin
            pulse_addr(1);
            repeat (4099) @(negedge clk);
        end
        chk("R6 integrator saturates high", int'(qos_out[1]), 15);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule